// File: doc/BRIEF.md
# Framed Serial Sampling-Converter Slave Interface

This block is the digital side of a four-channel sampling converter as seen from a host serial port. The host frames transfers with an active-low select line and supplies a serial clock. The block counts rising serial-clock edges inside each 16-edge word. For the first part of each word it drives a track request to the analog front end, and for the rest of the word it drives a hold/convert request. It reports power-down while the select line is high and in the short gap that follows each completed word.

The channel address for the next conversion arrives on the serial data input during the current word. It is committed only when the word completes, so the converter core always samples the channel that was requested one word earlier. A 12-bit result from an external converter core is captured on a parallel input at the start of the hold phase. It goes out on the serial data output behind four leading zeros, most significant bit first. The output pin is meant to be tristated by the pad using the enable output.

All serial pins are oversampled by the system clock through a synchronizer. Each serial-clock high and low phase must therefore last at least `SYNC_STAGES + 3` system clocks.

Top module: `sar_serial_slave`

## Requirements
- R1: While reset is asserted and after its release, before any serial traffic, chan_sel_o is 0, track_o and hold_o are 0, pwrdn_o is 1, dout_oe_o is 0 and dout_o is 0.
- R2: A word holds 16 rising SCLK edges counted from the select falling edge. After the 16th rising edge the count restarts, so back-to-back words in one frame each begin in track.
- R3: While the select is low, track_o is 1 until the 3rd rising edge of the word. hold_o is 1 from the 3rd rising edge up to the 16th. The two are never high together, and both are 0 while the select is high.
- R4: dout_oe_o is 1 exactly while the select is low, and dout_o is 0 while the select is high.
- R5: pwrdn_o is 1 while the select is high. It is also 1 from the 16th rising edge of a word until the next rising edge, and 0 at all other times.
- R6: The DIN values at the 4th and 5th rising edges of a word form the channel number, with the 4th edge giving bit 1 and the 5th giving bit 0. This number appears on chan_sel_o only after that word's 16th rising edge.
- R7: A word cut short by the select rising before its 16th edge leaves chan_sel_o unchanged. DIN values at edges other than the 4th and 5th have no effect on chan_sel_o.
- R8: sample_i is captured at the 3rd rising edge of each word, and later changes to it do not alter the bits sent in that word.
- R9: dout_o presents word bit k after the k-th falling edge of the word, with bit 0 presented from the select falling edge. Bits 0 to 3 are 0, and bits 4 to 15 carry the captured sample most significant bit first.
- R10: SCLK edges while the select is high change none of the outputs and do not advance the word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Active-low frame select from the host |
| sclk_i | input | 1 | Serial clock from the host |
| din_i | input | 1 | Serial address input |
| sample_i | input | SAMPLE_W | Parallel result from the converter core |
| dout_o | output | 1 | Serial result data |
| dout_oe_o | output | 1 | Pad enable for dout_o |
| track_o | output | 1 | Track request to the front end |
| hold_o | output | 1 | Hold/convert request to the front end |
| pwrdn_o | output | 1 | Power-down indication |
| chan_sel_o | output | CH_W | Input multiplexer select |

## Verification
A wrong word count shows within one serial-clock phase. The track/hold boundary moves off the 3rd edge, and the data bit on dout_o slips against the expected word position at the next falling edge. A bad address register stays hidden during the word and appears only at the 16th edge, when chan_sel_o takes a wrong value. For that reason, aborted words, reversed channel bit order and noisy non-address bits are each followed by a full word whose commit exposes the register. A sample captured at the wrong time shows as wrong data bits from bit 4 on, so the sample input is changed right after the 3rd edge of every word.

// File: rtl/sps_pkg.sv
package sps_pkg;

  typedef struct packed {
    logic cs_n;
    logic sclk;
    logic din;
  } pin_bus_t;

  localparam pin_bus_t PIN_IDLE = '{cs_n: 1'b1, sclk: 1'b0, din: 1'b0};

endpackage

// File: rtl/sps_sync.sv
module sps_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= RST_VAL;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= RST_VAL;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sps_word_ctr.sv
module sps_word_ctr #(
  parameter int WORD_LEN  = 16,
  parameter int TRACK_LEN = 3,
  parameter int CNT_W     = $clog2(WORD_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n_s,
  input  logic             sclk_rise,
  output logic [CNT_W-1:0] cnt_o,
  output logic             word_end_o,
  output logic             track_o,
  output logic             hold_o,
  output logic             pwrdn_o,
  output logic             oe_o
);

  localparam logic [CNT_W-1:0] LAST   = CNT_W'(WORD_LEN - 1);
  localparam logic [CNT_W-1:0] HOLD_AT = CNT_W'(TRACK_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic             gap_q;
  logic             edge_act;

  assign edge_act   = sclk_rise & ~cs_n_s;
  assign word_end_o = edge_act & (cnt_q == LAST);
  assign cnt_o      = cnt_q;

  // rising-edge count within the word, plus the post-word gap flag
  always_ff @(posedge clk) begin
    if (rst || cs_n_s) begin
      cnt_q <= '0;
      gap_q <= 1'b0;
    end else if (edge_act) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        gap_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        gap_q <= 1'b0;
      end
    end
  end

  // registered phase outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      track_o <= 1'b0;
      hold_o  <= 1'b0;
      pwrdn_o <= 1'b1;
      oe_o    <= 1'b0;
    end else begin
      track_o <= ~cs_n_s & (cnt_q < HOLD_AT);
      hold_o  <= ~cs_n_s & (cnt_q >= HOLD_AT);
      pwrdn_o <= cs_n_s | gap_q;
      oe_o    <= ~cs_n_s;
    end
  end

  // R2: the word boundary always opens the gap and restarts at zero count
  a_r2_wrap_gap : assert property (@(posedge clk) disable iff (rst)
    word_end_o |=> (cnt_q == '0) && gap_q);

endmodule

// File: rtl/sps_addr_pipe.sv
module sps_addr_pipe #(
  parameter int CNT_W      = 4,
  parameter int CH_W       = 2,
  parameter int ADDR_FIRST = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_act,
  input  logic [CNT_W-1:0] cnt,
  input  logic             din_s,
  input  logic             commit,
  output logic [CH_W-1:0]  chan_o
);

  logic [CH_W-1:0] pend_q;
  logic [CH_W-1:0] chan_q;

  // capture address bits MSB first at their rising-edge slots
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else if (edge_act) begin
      for (int i = 0; i < CH_W; i++) begin
        if (cnt == CNT_W'(ADDR_FIRST - 1 + i)) pend_q[CH_W-1-i] <= din_s;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         chan_q <= '0;
    else if (commit) chan_q <= pend_q;
  end

  assign chan_o = chan_q;

  // R7: the select moves only on a completed word
  a_r7_chan_steady : assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(chan_q));

endmodule

// File: rtl/sps_dout_shift.sv
module sps_dout_shift #(
  parameter int WORD_LEN  = 16,
  parameter int SAMPLE_W  = 12,
  parameter int TRACK_LEN = 3,
  parameter int CNT_W     = $clog2(WORD_LEN)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_n_s,
  input  logic                sclk_rise,
  input  logic                sclk_fall,
  input  logic [CNT_W-1:0]    cnt,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                dout_o
);

  localparam int ZPAD = WORD_LEN - SAMPLE_W;
  localparam logic [CNT_W-1:0] TOP_BIT = CNT_W'(WORD_LEN - 1);

  logic [SAMPLE_W-1:0] smp_q;
  logic [WORD_LEN-1:0] frame_w;
  logic                dout_q;

  assign frame_w = {{ZPAD{1'b0}}, smp_q};

  // sample captured on the edge that opens the hold phase
  always_ff @(posedge clk) begin
    if (rst) smp_q <= '0;
    else if (sclk_rise && !cs_n_s && cnt == CNT_W'(TRACK_LEN - 1)) smp_q <= sample_i;
  end

  always_ff @(posedge clk) begin
    if (rst || cs_n_s)   dout_q <= 1'b0;
    else if (sclk_fall)  dout_q <= frame_w[TOP_BIT - cnt];
  end

  assign dout_o = dout_q;

  // R9: the leading pad positions always present zero
  a_r9_pad_zero : assert property (@(posedge clk) disable iff (rst)
    (sclk_fall && !cs_n_s && cnt < CNT_W'(ZPAD)) |=> !dout_q);

endmodule

// File: rtl/sar_serial_slave.sv
module sar_serial_slave #(
  parameter int WORD_LEN    = 16,
  parameter int SAMPLE_W    = 12,
  parameter int CH_W        = 2,
  parameter int TRACK_LEN   = 3,
  parameter int ADDR_FIRST  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_n_i,
  input  logic                sclk_i,
  input  logic                din_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                dout_o,
  output logic                dout_oe_o,
  output logic                track_o,
  output logic                hold_o,
  output logic                pwrdn_o,
  output logic [CH_W-1:0]     chan_sel_o
);

  import sps_pkg::*;

  localparam int CNT_W = $clog2(WORD_LEN);

  pin_bus_t         pins_raw;
  pin_bus_t         pins_s;
  logic             sclk_prev;
  logic             sclk_rise;
  logic             sclk_fall;
  logic [CNT_W-1:0] cnt;
  logic             word_end;

  assign pins_raw = '{cs_n: cs_n_i, sclk: sclk_i, din: din_i};

  sps_sync #(
    .W       ($bits(pin_bus_t)),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_IDLE)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pins_raw),
    .q   (pins_s)
  );

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= PIN_IDLE.sclk;
    else     sclk_prev <= pins_s.sclk;
  end

  assign sclk_rise = pins_s.sclk & ~sclk_prev;
  assign sclk_fall = ~pins_s.sclk & sclk_prev;

  sps_word_ctr #(
    .WORD_LEN  (WORD_LEN),
    .TRACK_LEN (TRACK_LEN),
    .CNT_W     (CNT_W)
  ) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .cs_n_s     (pins_s.cs_n),
    .sclk_rise  (sclk_rise),
    .cnt_o      (cnt),
    .word_end_o (word_end),
    .track_o    (track_o),
    .hold_o     (hold_o),
    .pwrdn_o    (pwrdn_o),
    .oe_o       (dout_oe_o)
  );

  sps_addr_pipe #(
    .CNT_W      (CNT_W),
    .CH_W       (CH_W),
    .ADDR_FIRST (ADDR_FIRST)
  ) u_addr (
    .clk      (clk),
    .rst      (rst),
    .edge_act (sclk_rise & ~pins_s.cs_n),
    .cnt      (cnt),
    .din_s    (pins_s.din),
    .commit   (word_end),
    .chan_o   (chan_sel_o)
  );

  sps_dout_shift #(
    .WORD_LEN  (WORD_LEN),
    .SAMPLE_W  (SAMPLE_W),
    .TRACK_LEN (TRACK_LEN),
    .CNT_W     (CNT_W)
  ) u_dout (
    .clk       (clk),
    .rst       (rst),
    .cs_n_s    (pins_s.cs_n),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cnt       (cnt),
    .sample_i  (sample_i),
    .dout_o    (dout_o)
  );

  // R3: track and hold are mutually exclusive
  a_r3_phase_excl : assert property (@(posedge clk) disable iff (rst)
    !(track_o && hold_o));

  // R4 / R5: a high select gives a disabled pad and power-down one cycle later
  a_r4_oe_off : assert property (@(posedge clk) disable iff (rst)
    pins_s.cs_n |=> (!dout_oe_o && pwrdn_o && !track_o && !hold_o));

  // R4: a low select drives the pad one cycle later
  a_r4_oe_on : assert property (@(posedge clk) disable iff (rst)
    !pins_s.cs_n |=> dout_oe_o);

endmodule

// File: tb/sar_serial_slave_tb_top.sv
module sar_serial_slave_tb_top;

  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        din = 1'b0;
  logic [11:0] sample = 12'h000;
  logic        dout, dout_oe, track, hold, pwrdn;
  logic [1:0]  chan;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  bit          m_cs = 1;
  int          m_cnt = 0;
  bit          m_gap = 0;
  bit          m_dout = 0;
  logic [11:0] m_smp = '0;
  logic [1:0]  m_pend = '0;
  logic [1:0]  m_chan = '0;

  always #10 clk = ~clk;

  sar_serial_slave dut_i (
    .clk        (clk),
    .rst        (rst),
    .cs_n_i     (cs_n),
    .sclk_i     (sclk),
    .din_i      (din),
    .sample_i   (sample),
    .dout_o     (dout),
    .dout_oe_o  (dout_oe),
    .track_o    (track),
    .hold_o     (hold),
    .pwrdn_o    (pwrdn),
    .chan_sel_o (chan)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic settle_cmp(input string tag);
    repeat (H) @(posedge clk);
    @(negedge clk);
    chk({tag, " R3"}, "track", int'(track), int'(!m_cs && m_cnt < 3));
    chk({tag, " R3"}, "hold",  int'(hold),  int'(!m_cs && m_cnt >= 3));
    chk({tag, " R5"}, "pwrdn", int'(pwrdn), int'(m_cs || m_gap));
    chk({tag, " R4"}, "oe",    int'(dout_oe), int'(!m_cs));
    chk({tag, " R9"}, "dout",  int'(dout),  int'(m_dout));
    chk({tag, " R6"}, "chan",  int'(chan),  int'(m_chan));
  endtask

  task automatic sel_low(input string tag);
    cs_n = 1'b0;
    m_cs = 0; m_cnt = 0; m_gap = 0; m_dout = 0;
    settle_cmp(tag);
  endtask

  task automatic sel_high(input string tag);
    cs_n = 1'b1;
    m_cs = 1; m_cnt = 0; m_gap = 0; m_dout = 0;
    settle_cmp(tag);
  endtask

  task automatic do_rise(input bit d, input string tag);
    din = d;
    repeat (2) @(posedge clk);
    sclk = 1'b1;
    if (!m_cs) begin
      int r = m_cnt + 1;
      if (r == 3) m_smp = sample;
      if (r == 4) m_pend[1] = d;
      if (r == 5) m_pend[0] = d;
      if (r == 16) begin
        m_cnt = 0; m_gap = 1; m_chan = m_pend;
      end else begin
        m_cnt = r; m_gap = 0;
      end
    end
    settle_cmp(tag);
  endtask

  task automatic do_fall(input string tag);
    sclk = 1'b0;
    if (!m_cs) m_dout = (m_cnt >= 4) ? m_smp[15 - m_cnt] : 1'b0;
    settle_cmp(tag);
  endtask

  task automatic word(input logic [1:0] a, input logic [11:0] s, input logic [11:0] alt,
                      input bit noise, input int nrise, input string tag);
    sample = s;
    for (int r = 1; r <= nrise; r++) begin
      bit d;
      d = (r == 4) ? a[1] : (r == 5) ? a[0] : (noise ^ r[0]);
      do_rise(d, tag);
      if (r == 3) sample = alt;  // R8: late change must not leak
      do_fall(tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish act=hung exp=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1: state during reset
    chk("R1", "pwrdn in reset", int'(pwrdn), 1);
    chk("R1", "oe in reset", int'(dout_oe), 0);
    rst = 1'b0;
    settle_cmp("R1 after reset");

    // R10: clock edges with select high
    for (int i = 0; i < 3; i++) begin
      do_rise(1'b1, "R10 idle clocks");
      do_fall("R10 idle clocks");
    end

    // single word, channel 2
    sel_low("R2 frame start");
    word(2'b10, 12'hA5C, 12'h3F0, 1'b1, 16, "R8 word a");
    sel_high("R6 frame end");

    // three back-to-back words in one frame
    sel_low("R2 burst");
    word(2'b01, 12'h801, 12'h000, 1'b0, 16, "R2 burst w1");
    word(2'b11, 12'h7FE, 12'hFFF, 1'b1, 16, "R2 burst w2");
    word(2'b00, 12'hFFF, 12'h555, 1'b1, 16, "R2 burst w3");
    sel_high("R5 burst end");

    // aborted word requesting channel 3
    sel_low("R7 abort");
    word(2'b11, 12'h123, 12'h321, 1'b1, 10, "R7 abort");
    sel_high("R7 abort end");
    chk("R7", "chan after abort", int'(chan), 0);

    // noise on non-address slots, channel 1
    sel_low("R7 noise");
    word(2'b01, 12'h6B9, 12'h946, 1'b1, 16, "R7 noise");
    sel_high("R7 noise end");

    // idle clocks then a word, checking restart at track
    for (int i = 0; i < 2; i++) begin
      do_rise(1'b0, "R10 idle clocks 2");
      do_fall("R10 idle clocks 2");
    end
    sel_low("R10 restart");
    word(2'b10, 12'h001, 12'hFFE, 1'b0, 16, "R9 lsb word");
    sel_high("R9 end");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule